// File: doc/BRIEF.md
# Configurable Macrocell Register Slice

This block models one output cell of a programmable-logic device. It receives a sum-of-products term from the logic array, a direct value from an input pad, a small set of global clocks and a clock built from a local product term. Static configuration inputs choose between a pure combinational path and a storage element. The storage element can be set up as an edge-triggered D flip-flop, a toggle flip-flop or a level-sensitive transparent latch. Per-cell options cover clock source and phase, dual-edge capture, clock enable, direct-pin data, local and global forcing to 0 or 1, and a programmed initial value.

The whole cell runs on one fast system clock `clk`. The selected cell clock is treated as a sampled data signal. Its edges and level are detected inside the block. Set and clear forcing takes effect on the next system clock edge, whatever the state of the selected cell clock. `rst` is a synchronous, active-high initialization input. It loads the configured initial value into the storage element.

Top module: `mc_slice`

## Requirements
- R1: While `rst` is high at a `clk` edge, the storage element takes `cfg_init` and `oe_out` goes to 0. `q_out` shows `cfg_init` when `cfg_registered`=1 and 0 otherwise. Both appear one `clk` edge later.
- R2: When `cfg_registered`=0, `q_out` equals `sop_in` as sampled at the previous `clk` edge. The clock, clock-enable and mode inputs have no effect on it.
- R3: `cfg_clk_sel` values 0 to NGCLK-1 select `gclk[cfg_clk_sel]`, and value NGCLK or above selects `pt_clk`. Edges on the sources that are not selected change nothing.
- R4: With `cfg_clk_inv`=1 the selected source is inverted before edge detection, so the falling edge of the source captures data.
- R5: With `cfg_mode`=0 (D), a rising edge of the phase-adjusted clock stores D. A rising edge means the clock is 1 at this `clk` edge and was 0 at the previous one. The new value appears on `q_out` one `clk` edge later. Between edges the value holds.
- R6: With `cfg_dual_edge`=1 in D or T mode, falling edges of the phase-adjusted clock also qualify.
- R7: With `cfg_mode`=1 (T), a qualifying edge inverts the stored bit when D is 1 and leaves it unchanged when D is 0.
- R8: With `cfg_mode`=2 (latch), the stored bit follows D whenever the phase-adjusted clock is 1, and holds while it is 0. `cfg_dual_edge` has no effect in this mode.
- R9: With `cfg_use_ce`=1 and `pt_ce`=0, the storage element ignores clock edges and latch transparency. With `cfg_use_ce`=0, `pt_ce` is ignored.
- R10: D is `pin_in` when `cfg_pin_d`=1 and `sop_in` when it is 0.
- R11: `pt_set`=1 forces the stored bit to 1 and `pt_rst`=1 forces it to 0. Both act on the next `clk` edge without any cell-clock edge. When both are high, clearing wins.
- R12: When `cfg_gsr_en`=1, `gsr`=1 forces the stored bit to 1 if `cfg_gsr_set`=1 and to 0 if `cfg_gsr_set`=0. When `cfg_gsr_en`=0, `gsr` is ignored.
- R13: Outside reset, `oe_out` is `pt_oe` sampled at the previous `clk` edge when `cfg_oe_pt`=1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Synchronous initialization, active high |
| sop_in | input | 1 | Sum-of-products term from the logic array |
| pin_in | input | 1 | Direct pad input |
| gclk | input | NGCLK | Global clock sources |
| pt_clk | input | 1 | Local product-term clock |
| pt_ce | input | 1 | Product-term clock enable |
| pt_set | input | 1 | Local force-to-1 |
| pt_rst | input | 1 | Local force-to-0 |
| pt_oe | input | 1 | Product-term output enable |
| gsr | input | 1 | Global set/reset line |
| cfg_registered | input | 1 | 1 selects the storage path, 0 the combinational path |
| cfg_mode | input | 2 | 0 D flip-flop, 1 T flip-flop, 2 latch |
| cfg_clk_sel | input | SEL_W | Clock source index |
| cfg_clk_inv | input | 1 | Invert the selected clock |
| cfg_dual_edge | input | 1 | Capture on both edges |
| cfg_use_ce | input | 1 | Honour `pt_ce` |
| cfg_pin_d | input | 1 | Take D from `pin_in` |
| cfg_init | input | 1 | Initial stored value |
| cfg_gsr_en | input | 1 | Respond to `gsr` |
| cfg_gsr_set | input | 1 | `gsr` sets (1) or clears (0) |
| cfg_oe_pt | input | 1 | Drive enable from `pt_oe` |
| q_out | output | 1 | Registered cell output |
| oe_out | output | 1 | Registered output enable |

## Verification
On every cycle the assertions check several rules. Local clearing forces `q_out` to 0 and beats setting. Local or global setting forces it to 1. The combinational path echoes `sop_in` one cycle later. `oe_out` follows its source. A disabled clock enable freezes the stored output. The bench's scenarios alone can show the parts that depend on edge history: which clock source and phase capture data, dual-edge capture, toggling, latch transparency and hold, pin-sourced data, the ignored global line, and the reset value in both path settings.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MC_DFF   = 2'd0,
    MC_TFF   = 2'd1,
    MC_LATCH = 2'd2
  } mc_mode_e;
endpackage

// File: rtl/mc_clk_pick.sv
// Chooses the cell clock, applies phase inversion and detects edges
// against the value seen at the previous system clock edge.
module mc_clk_pick #(
  parameter int NGCLK = 3,
  parameter int SEL_W = $clog2(NGCLK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NGCLK-1:0] gclk,
  input  logic             pt_clk,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  output logic             lvl,
  output logic             rise,
  output logic             fall
);
  localparam logic [SEL_W-1:0] LOCAL_SEL = SEL_W'(NGCLK);

  logic [NGCLK-1:0] hit;
  logic             src;
  logic             prev;

  genvar gi;
  generate
    for (gi = 0; gi < NGCLK; gi++) begin : g_hit
      assign hit[gi] = (sel == SEL_W'(gi)) & gclk[gi];
    end
  endgenerate

  always_comb begin
    src = (|hit) | ((sel >= LOCAL_SEL) & pt_clk);
    lvl = src ^ inv;
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/mc_force_ctl.sv
// Merges local and global forcing sources; clearing has priority.
module mc_force_ctl (
  input  logic pt_set,
  input  logic pt_rst,
  input  logic gsr,
  input  logic gsr_en,
  input  logic gsr_set,
  output logic force_set,
  output logic force_clr
);
  logic g_act;

  always_comb begin
    g_act     = gsr_en & gsr;
    force_clr = pt_rst | (g_act & ~gsr_set);
    force_set = ~force_clr & (pt_set | (g_act & gsr_set));
  end
endmodule

// File: rtl/mc_store.sv
// Single storage bit acting as D flip-flop, toggle flip-flop or latch.
module mc_store
  import mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     init,
  input  mc_mode_e mode,
  input  logic     d,
  input  logic     lvl,
  input  logic     rise,
  input  logic     fall,
  input  logic     dual,
  input  logic     ce,
  input  logic     force_set,
  input  logic     force_clr,
  output logic     st_nxt
);
  logic st;
  logic edge_ok;

  always_comb begin
    edge_ok = rise | (dual & fall);
    st_nxt  = st;
    unique case (mode)
      MC_DFF:   if (edge_ok & ce) st_nxt = d;
      MC_TFF:   if (edge_ok & ce & d) st_nxt = ~st;
      MC_LATCH: if (lvl & ce) st_nxt = d;
      default:  st_nxt = st;
    endcase
    if (force_clr)      st_nxt = 1'b0;
    else if (force_set) st_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= init;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/mc_slice.sv
module mc_slice
  import mc_pkg::*;
#(
  parameter int NGCLK = 3,
  parameter int SEL_W = $clog2(NGCLK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sop_in,
  input  logic             pin_in,
  input  logic [NGCLK-1:0] gclk,
  input  logic             pt_clk,
  input  logic             pt_ce,
  input  logic             pt_set,
  input  logic             pt_rst,
  input  logic             pt_oe,
  input  logic             gsr,
  input  logic             cfg_registered,
  input  logic [1:0]       cfg_mode,
  input  logic [SEL_W-1:0] cfg_clk_sel,
  input  logic             cfg_clk_inv,
  input  logic             cfg_dual_edge,
  input  logic             cfg_use_ce,
  input  logic             cfg_pin_d,
  input  logic             cfg_init,
  input  logic             cfg_gsr_en,
  input  logic             cfg_gsr_set,
  input  logic             cfg_oe_pt,
  output logic             q_out,
  output logic             oe_out
);
  logic lvl, rise, fall;
  logic force_set, force_clr;
  logic d_sel, ce_eff, st_nxt;

  assign d_sel  = cfg_pin_d ? pin_in : sop_in;
  assign ce_eff = ~cfg_use_ce | pt_ce;

  mc_clk_pick #(.NGCLK(NGCLK), .SEL_W(SEL_W)) u_clk (
    .clk(clk), .rst(rst), .gclk(gclk), .pt_clk(pt_clk),
    .sel(cfg_clk_sel), .inv(cfg_clk_inv),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  mc_force_ctl u_force (
    .pt_set(pt_set), .pt_rst(pt_rst), .gsr(gsr),
    .gsr_en(cfg_gsr_en), .gsr_set(cfg_gsr_set),
    .force_set(force_set), .force_clr(force_clr)
  );

  mc_store u_store (
    .clk(clk), .rst(rst), .init(cfg_init), .mode(mc_mode_e'(cfg_mode)),
    .d(d_sel), .lvl(lvl), .rise(rise), .fall(fall),
    .dual(cfg_dual_edge), .ce(ce_eff),
    .force_set(force_set), .force_clr(force_clr),
    .st_nxt(st_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q_out  <= cfg_registered & cfg_init;
      oe_out <= 1'b0;
    end else begin
      q_out  <= cfg_registered ? st_nxt : sop_in;
      oe_out <= cfg_oe_pt ? pt_oe : 1'b1;
    end
  end
endmodule

// File: rtl/mc_slice_chk.sv
module mc_slice_chk (
  input logic       clk,
  input logic       rst,
  input logic       sop_in,
  input logic       pt_ce,
  input logic       pt_set,
  input logic       pt_rst,
  input logic       pt_oe,
  input logic       gsr,
  input logic       cfg_registered,
  input logic       cfg_use_ce,
  input logic       cfg_gsr_en,
  input logic       cfg_gsr_set,
  input logic       cfg_oe_pt,
  input logic       q_out,
  input logic       oe_out
);
  // R11
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_registered && pt_rst) |=> !q_out);

  // R11 R12
  set_force_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_registered && !pt_rst && !(cfg_gsr_en && gsr && !cfg_gsr_set) &&
     (pt_set || (cfg_gsr_en && gsr && cfg_gsr_set))) |=> q_out);

  // R2
  comb_path_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_registered |=> (q_out == $past(sop_in)));

  // R13
  oe_src_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (oe_out == ($past(cfg_oe_pt) ? $past(pt_oe) : 1'b1)));

  // R9
  ce_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_registered && $past(cfg_registered) && cfg_use_ce && !pt_ce &&
     !pt_set && !pt_rst && !(cfg_gsr_en && gsr)) |=> $stable(q_out));
endmodule

bind mc_slice mc_slice_chk u_chk (
  .clk(clk), .rst(rst), .sop_in(sop_in), .pt_ce(pt_ce),
  .pt_set(pt_set), .pt_rst(pt_rst), .pt_oe(pt_oe), .gsr(gsr),
  .cfg_registered(cfg_registered), .cfg_use_ce(cfg_use_ce),
  .cfg_gsr_en(cfg_gsr_en), .cfg_gsr_set(cfg_gsr_set),
  .cfg_oe_pt(cfg_oe_pt), .q_out(q_out), .oe_out(oe_out)
);

// File: tb/tb_mc_slice.sv
`timescale 1ns/1ps
module tb_mc_slice;
  localparam int NGCLK = 3;
  localparam int SEL_W = $clog2(NGCLK + 1);

  logic clk = 1'b0;
  logic rst;
  logic sop_in, pin_in, pt_clk, pt_ce, pt_set, pt_rst, pt_oe, gsr;
  logic [NGCLK-1:0] gclk;
  logic cfg_registered, cfg_clk_inv, cfg_dual_edge, cfg_use_ce, cfg_pin_d;
  logic cfg_init, cfg_gsr_en, cfg_gsr_set, cfg_oe_pt;
  logic [1:0] cfg_mode;
  logic [SEL_W-1:0] cfg_clk_sel;
  logic q_out, oe_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic  exp_q_fifo[$];
  logic  exp_oe_fifo[$];
  bit    use_oe_fifo[$];
  string tag_fifo[$];

  always #5 clk = ~clk;

  mc_slice #(.NGCLK(NGCLK), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst(rst), .sop_in(sop_in), .pin_in(pin_in), .gclk(gclk),
    .pt_clk(pt_clk), .pt_ce(pt_ce), .pt_set(pt_set), .pt_rst(pt_rst),
    .pt_oe(pt_oe), .gsr(gsr), .cfg_registered(cfg_registered),
    .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv),
    .cfg_dual_edge(cfg_dual_edge), .cfg_use_ce(cfg_use_ce),
    .cfg_pin_d(cfg_pin_d), .cfg_init(cfg_init), .cfg_gsr_en(cfg_gsr_en),
    .cfg_gsr_set(cfg_gsr_set), .cfg_oe_pt(cfg_oe_pt),
    .q_out(q_out), .oe_out(oe_out)
  );

  // Monitor: pops one expectation per clock edge and compares.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q_fifo.size() > 0) begin
        logic  eq, eo;
        bit    uo;
        string tg;
        eq = exp_q_fifo.pop_front();
        eo = exp_oe_fifo.pop_front();
        uo = use_oe_fifo.pop_front();
        tg = tag_fifo.pop_front();
        checks++;
        if (q_out !== eq) begin
          errors++;
          $display("FAIL %s q_out actual %b expected %b", tg, q_out, eq);
        end
        if (uo) begin
          checks++;
          if (oe_out !== eo) begin
            errors++;
            $display("FAIL %s oe_out actual %b expected %b", tg, oe_out, eo);
          end
        end
      end
    end
  end

  // Driver: queue the expectation for the coming edge, then advance.
  task automatic step(input logic eq, input string tg);
    exp_q_fifo.push_back(eq);
    exp_oe_fifo.push_back(1'b0);
    use_oe_fifo.push_back(1'b0);
    tag_fifo.push_back(tg);
    @(posedge clk);
    #2;
  endtask

  task automatic step_oe(input logic eq, input logic eo, input string tg);
    exp_q_fifo.push_back(eq);
    exp_oe_fifo.push_back(eo);
    use_oe_fifo.push_back(1'b1);
    tag_fifo.push_back(tg);
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; sop_in = 0; pin_in = 0; gclk = '0; pt_clk = 0; pt_ce = 0;
    pt_set = 0; pt_rst = 0; pt_oe = 0; gsr = 0;
    cfg_registered = 1; cfg_mode = 2'd0; cfg_clk_sel = '0; cfg_clk_inv = 0;
    cfg_dual_edge = 0; cfg_use_ce = 0; cfg_pin_d = 0; cfg_init = 1;
    cfg_gsr_en = 0; cfg_gsr_set = 0; cfg_oe_pt = 0;
    #2;
    // R1: reset loads the initial value, enable low
    step_oe(1, 0, "R1 reset");
    step_oe(1, 0, "R1 reset");
    rst = 0;
    step_oe(1, 1, "R1 after reset / R13 default enable");

    // R5: D capture on rising edge only
    sop_in = 0; gclk[0] = 1; step(0, "R5 rise captures 0");
    sop_in = 1;              step(0, "R5 no edge holds");
    gclk[0] = 0;             step(0, "R5 fall ignored");
    gclk[0] = 1;             step(1, "R5 rise captures 1");
    gclk[0] = 0;             step(1, "R5 hold");

    // R3: clock source selection
    cfg_clk_sel = 2'd1; sop_in = 0;
    gclk[0] = 1;             step(1, "R3 unselected gclk0 ignored");
    gclk[0] = 0; gclk[1] = 1; step(0, "R3 gclk1 captures");
    gclk[1] = 0; sop_in = 1; step(0, "R3 hold");
    cfg_clk_sel = 2'd3; pt_clk = 1; step(1, "R3 local clock captures");
    pt_clk = 0; cfg_clk_sel = 2'd0; step(1, "R3 switch back holds");

    // R4: phase inversion
    cfg_clk_inv = 1; gclk[0] = 1; sop_in = 0; step(1, "R4 source rise ignored");
    gclk[0] = 0;             step(0, "R4 source fall captures");
    sop_in = 1; gclk[0] = 1; step(0, "R4 source rise holds");
    gclk[0] = 0;             step(1, "R4 source fall captures 1");
    cfg_clk_inv = 0;         step(1, "R4 restore holds");

    // R6: dual-edge capture
    cfg_dual_edge = 1; sop_in = 0; gclk[0] = 1; step(0, "R6 rise");
    sop_in = 1; gclk[0] = 0; step(1, "R6 fall captures");
    sop_in = 0;              step(1, "R6 hold");
    cfg_dual_edge = 0;

    // R7: toggle mode
    cfg_mode = 2'd1; sop_in = 1; gclk[0] = 1; step(0, "R7 toggle to 0");
    gclk[0] = 0;             step(0, "R7 fall no toggle");
    sop_in = 0; gclk[0] = 1; step(0, "R7 T=0 holds");
    gclk[0] = 0;             step(0, "R7 hold");
    sop_in = 1; gclk[0] = 1; step(1, "R7 toggle to 1");
    gclk[0] = 0;             step(1, "R7 hold");

    // R9: clock enable
    cfg_mode = 2'd0; cfg_use_ce = 1; pt_ce = 0; sop_in = 0;
    gclk[0] = 1;             step(1, "R9 CE low blocks edge");
    gclk[0] = 0;             step(1, "R9 hold");
    pt_ce = 1; gclk[0] = 1;  step(0, "R9 CE high captures");
    gclk[0] = 0;             step(0, "R9 hold");
    cfg_use_ce = 0; pt_ce = 0; sop_in = 1;
    gclk[0] = 1;             step(1, "R9 CE ignored when unused");
    gclk[0] = 0;             step(1, "R9 hold");

    // R10: direct pin data
    cfg_pin_d = 1; pin_in = 0; sop_in = 1;
    gclk[0] = 1;             step(0, "R10 pin 0 captured");
    gclk[0] = 0;             step(0, "R10 hold");
    pin_in = 1; sop_in = 0; gclk[0] = 1; step(1, "R10 pin 1 captured");
    gclk[0] = 0; cfg_pin_d = 0; step(1, "R10 hold");

    // R8: latch mode
    cfg_mode = 2'd2; sop_in = 0; gclk[0] = 1; step(0, "R8 transparent 0");
    sop_in = 1;              step(1, "R8 transparent 1");
    gclk[0] = 0; sop_in = 0; step(1, "R8 closed holds");
    cfg_dual_edge = 1;       step(1, "R8 dual edge no effect");
    cfg_dual_edge = 0; cfg_use_ce = 1; pt_ce = 0; gclk[0] = 1;
    step(1, "R8 R9 CE blocks latch");
    cfg_use_ce = 0;          step(0, "R8 transparent again");
    gclk[0] = 0;             step(0, "R8 hold");

    // R11: local forcing
    cfg_mode = 2'd0; sop_in = 0;
    pt_set = 1;              step(1, "R11 set");
    pt_rst = 1;              step(0, "R11 clear wins");
    pt_rst = 0;              step(1, "R11 set alone");
    pt_set = 0;              step(1, "R11 hold");

    // R12: global set/reset
    gsr = 1; cfg_gsr_en = 0; cfg_gsr_set = 0; step(1, "R12 gsr ignored when disabled");
    cfg_gsr_en = 1;          step(0, "R12 gsr clears");
    cfg_gsr_set = 1;         step(1, "R12 gsr sets");
    cfg_gsr_set = 0;         step(0, "R12 gsr clears again");
    gsr = 0; cfg_gsr_en = 0; step(0, "R12 hold");

    // R2: combinational path
    cfg_registered = 0; sop_in = 1; step(1, "R2 pass 1");
    cfg_use_ce = 1; pt_ce = 0; gclk[0] = 1; sop_in = 0; step(0, "R2 pass 0 CE ignored");
    gclk[0] = 0; sop_in = 1; step(1, "R2 pass 1 clock ignored");
    cfg_use_ce = 0;

    // R13: output enable source
    cfg_oe_pt = 1; pt_oe = 0; step_oe(1, 0, "R13 enable from term 0");
    pt_oe = 1;               step_oe(1, 1, "R13 enable from term 1");
    cfg_oe_pt = 0; pt_oe = 0; step_oe(1, 1, "R13 constant enable");

    // R1: reset with other settings
    cfg_registered = 1; cfg_init = 0; rst = 1; step_oe(0, 0, "R1 init 0");
    rst = 0;                 step_oe(0, 1, "R1 released");
    cfg_registered = 0; cfg_init = 1; sop_in = 1; rst = 1;
    step_oe(0, 0, "R1 combinational reset value");
    rst = 0;                 step_oe(1, 1, "R1 released comb");

    @(posedge clk);
    #3;
    finish_run();
  end
endmodule